// File: doc/BRIEF.md
# Multi-Cycle Byte-Wide Processor Core

This core is an 8-bit processor with a 16-bit address space. It runs one instruction at a time over several clock cycles. It fetches a one-byte instruction, then any operand or address bytes, and then carries out the operation. The operation can be ALU work on the register file, a memory load or store, a stack push or pop, a conditional jump, or an I/O port access. The core holds four general registers, an address pair (high and low halves), a flags byte, a stack pointer and a program counter.

Memory is reached through a single valid/ready request channel. The core raises `mem_valid` with an address, a direction and (for writes) data. The transfer completes on the first rising edge where `mem_ready` is also high, and read data is taken on that same edge. While `mem_ready` is low the request stays exactly as it is, so a slow memory can stall the core for any number of cycles.

The I/O bus is plain: a one-cycle read or write strobe with a port number. Read data is sampled on the same edge as the strobe. Port 0 is handled inside the core and holds the halt bit. The stack pointer and program counter also appear as bytes at the top four memory addresses. The core serves those addresses internally.

Top module: `cpu8_core`

## Requirements
- R1: After reset, PC is 0x0000, SP is 0x7C00, and all registers and flags read 0. The first bus request is a read of address 0x0000, and `halted` is low.
- R2: A memory transfer happens on a rising edge with `mem_valid` and `mem_ready` both high. While `mem_ready` is low, `mem_addr`, `mem_we` and `mem_wdata` hold steady and `mem_valid` stays high. Accesses occur in program order: instruction byte, then operand or address bytes at increasing PC, then the data access.
- R3: An instruction byte carries the opcode in bits 7:4, a mode flag in bit 3 and a register number in bits 2:0. For ALU ops, jump, push and port ops, the next byte is the operand. In mode 0 that byte is used directly. In mode 1 only its bits 2:0 are used, and they name the source register.
- R4: Opcodes 0 to 7 act on dest and src as follows: 0 add, 1 add with carry-in, 2 subtract, 3 AND, 4 OR, 5 NOR, 6 compare (no register write), 7 copy src into dest.
- R5: The flags byte is register 7, with carry in bit 0, zero in bit 1, equal in bit 2 and greater in bit 3. Opcodes 0 to 5 set zero from the result. Add sets carry to the carry-out, subtract sets it to the borrow, and the logic ops clear it. Compare sets carry to the borrow, sets zero and equal when the operands match, and sets greater when dest exceeds src (unsigned). Copy leaves the flags alone. An ALU result whose destination is register 7 replaces the flags outright.
- R6: Register 6 always reads as 0, and writes to it are dropped. Registers 4 and 5 form the address pair HL (H in the high byte).
- R7: Opcode 8 loads dest from memory and opcode 9 stores it. The address comes from HL in mode 1. In mode 0 it is a two-byte address that follows the instruction, low byte first. Opcode A loads HL from a two-byte value in the same order.
- R8: Opcode B sets PC to HL when its operand is nonzero. Otherwise execution continues with the next instruction.
- R9: Opcode C writes its operand at SP and then adds 1 to SP. Opcode D subtracts 1 from SP and then reads that address into dest. Opcode D has no operand byte.
- R10: Addresses 0xFFFC/0xFFFD read and write SP low/high, and 0xFFFE/0xFFFF read and write PC low/high. Such an access makes no bus request. PC reads give the address just after the current instruction's last byte.
- R11: Opcode E reads the operand-numbered port into dest, and opcode F writes dest to that port. Each raises a one-cycle `io_rd` or `io_wr`, and the two never rise together.
- R12: Port 0 is internal and raises no strobe. Reading it returns the halt bit in bit 0. Writing it with bit 0 set halts the core, and writing it with bit 0 clear does nothing. Once halted, `halted` stays high and no memory or port request is made until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts the request on this edge |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, sampled at acceptance |
| io_rd | output | 1 | Port read strobe |
| io_wr | output | 1 | Port write strobe |
| io_addr | output | 8 | Port number |
| io_wdata | output | 8 | Port write data |
| io_rdata | input | 8 | Port read data, sampled with `io_rd` |
| halted | output | 1 | Core has stopped |

## Verification
The hardest situation to reach from the pins is a memory-mapped access to SP or PC. It shows up only as a missing bus transaction and a changed later stack address. The program loads the PC bytes and stores them back to RAM, and it rewrites the SP low byte before pushing and popping. The effect then surfaces as bus writes with known data. The stimulus holds `mem_ready` low in a pseudo-random pattern throughout, so every fetch, operand and data access is also exercised under back-pressure. The run ends on a port-0 write that must halt the core before a store that follows it.

// File: rtl/cpu8_pkg.sv
package cpu8_pkg;
  localparam int DW  = 8;
  localparam int AW  = 16;
  localparam int RIW = 3;
  localparam int NREG = 1 << RIW;

  localparam logic [RIW-1:0] RID_H    = 3'd4;
  localparam logic [RIW-1:0] RID_L    = 3'd5;
  localparam logic [RIW-1:0] RID_NULL = 3'd6;
  localparam logic [RIW-1:0] RID_FLG  = 3'd7;

  localparam int F_C = 0;
  localparam int F_Z = 1;
  localparam int F_E = 2;
  localparam int F_G = 3;

  typedef enum logic [3:0] {
    OP_ADD, OP_ADC, OP_SUB, OP_AND, OP_OR, OP_NOR, OP_CMP, OP_MOV,
    OP_LDW, OP_STW, OP_LDHL, OP_JNZ, OP_PUSH, OP_POP, OP_IN, OP_OUT
  } op_e;

  typedef enum logic [2:0] {
    S_FETCH, S_DECODE, S_OPND, S_ALO, S_AHI, S_MEM, S_EXEC, S_HALT
  } st_e;
endpackage

// File: rtl/cpu8_alu.sv
module cpu8_alu
  import cpu8_pkg::*;
(
  input  logic [2:0]    fn,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [DW-1:0] fl_in,
  output logic [DW-1:0] y,
  output logic [DW-1:0] fl_out,
  output logic          dst_we,
  output logic          fl_we
);
  logic [DW:0] ext;

  always_comb begin
    ext    = '0;
    dst_we = 1'b1;
    fl_we  = 1'b1;
    fl_out = fl_in;
    case (fn)
      3'd0:       ext = {1'b0, a} + {1'b0, b};
      3'd1:       ext = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, fl_in[F_C]};
      3'd2, 3'd6: ext = {1'b0, a} - {1'b0, b};
      3'd3:       ext = {1'b0, a & b};
      3'd4:       ext = {1'b0, a | b};
      3'd5:       ext = {1'b0, ~(a | b)};
      default:    ext = {1'b0, b};
    endcase
    y           = ext[DW-1:0];
    fl_out[F_C] = ext[DW];
    fl_out[F_Z] = (y == '0);
    if (fn == 3'd6) begin
      dst_we      = 1'b0;
      fl_out[F_E] = (a == b);
      fl_out[F_G] = (a > b);
    end
    if (fn == 3'd7) fl_we = 1'b0;
  end
endmodule

// File: rtl/cpu8_regs.sv
module cpu8_regs
  import cpu8_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [RIW-1:0] ra,
  input  logic [RIW-1:0] rb,
  output logic [DW-1:0]  rd_a,
  output logic [DW-1:0]  rd_b,
  input  logic           we,
  input  logic [RIW-1:0] wa,
  input  logic [DW-1:0]  wd,
  input  logic           fl_we,
  input  logic [DW-1:0]  fl_d,
  input  logic           hl_we,
  input  logic [AW-1:0]  hl_d,
  output logic [AW-1:0]  hl,
  output logic [DW-1:0]  flags
);
  logic [DW-1:0] rf [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else begin
      if (hl_we) begin
        rf[RID_H] <= hl_d[AW-1:DW];
        rf[RID_L] <= hl_d[DW-1:0];
      end
      if (fl_we) rf[RID_FLG] <= fl_d;
      if (we && wa != RID_NULL) rf[wa] <= wd;
    end
  end

  assign rd_a  = (ra == RID_NULL) ? '0 : rf[ra];
  assign rd_b  = (rb == RID_NULL) ? '0 : rf[rb];
  assign hl    = {rf[RID_H], rf[RID_L]};
  assign flags = rf[RID_FLG];
endmodule

// File: rtl/cpu8_core.sv
module cpu8_core
  import cpu8_pkg::*;
#(
  parameter logic [AW-1:0] SP_INIT   = 16'h7C00,
  parameter logic [AW-1:0] MMIO_BASE = 16'hFFFC
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          io_rd,
  output logic          io_wr,
  output logic [DW-1:0] io_addr,
  output logic [DW-1:0] io_wdata,
  input  logic [DW-1:0] io_rdata,
  output logic          halted
);
  st_e            st;
  logic [DW-1:0]  ir, opnd, alo;
  logic [AW-1:0]  pc, sp, ea, hl;
  op_e            op;
  logic           mode, mmio, is_store, is_load, port0;
  logic [RIW-1:0] rid;
  logic [DW-1:0]  rd_a, rd_b, val, flags, mm_val, ld_val;
  logic [DW-1:0]  alu_y, alu_fl;
  logic           alu_dwe, alu_fwe;
  logic           rf_we, fl_we, hl_we;
  logic [DW-1:0]  rf_wd;

  assign op       = op_e'(ir[7:4]);
  assign mode     = ir[3];
  assign rid      = ir[2:0];
  assign val      = mode ? rd_b : opnd;
  assign mmio     = (ea >= MMIO_BASE);
  assign is_store = (op == OP_STW) || (op == OP_PUSH);
  assign is_load  = (op == OP_LDW) || (op == OP_POP);
  assign port0    = (val == '0);

  always_comb begin
    case (ea[1:0])
      2'd0:    mm_val = sp[DW-1:0];
      2'd1:    mm_val = sp[AW-1:DW];
      2'd2:    mm_val = pc[DW-1:0];
      default: mm_val = pc[AW-1:DW];
    endcase
  end
  assign ld_val = mmio ? mm_val : mem_rdata;

  assign mem_valid = (st == S_FETCH) || (st == S_OPND) || (st == S_ALO) ||
                     (st == S_AHI) || ((st == S_MEM) && !mmio);
  assign mem_addr  = (st == S_MEM) ? ea : pc;
  assign mem_we    = (st == S_MEM) && is_store;
  assign mem_wdata = (op == OP_PUSH) ? opnd : rd_a;

  assign io_rd    = (st == S_EXEC) && (op == OP_IN) && !port0;
  assign io_wr    = (st == S_EXEC) && (op == OP_OUT) && !port0;
  assign io_addr  = val;
  assign io_wdata = rd_a;
  assign halted   = (st == S_HALT);

  cpu8_alu u_alu (
    .fn(ir[6:4]), .a(rd_a), .b(val), .fl_in(flags),
    .y(alu_y), .fl_out(alu_fl), .dst_we(alu_dwe), .fl_we(alu_fwe)
  );

  always_comb begin
    rf_we = 1'b0;
    fl_we = 1'b0;
    rf_wd = alu_y;
    if (st == S_EXEC && !ir[7]) begin
      rf_we = alu_dwe;
      fl_we = alu_fwe;
    end else if (st == S_EXEC && op == OP_IN) begin
      rf_we = 1'b1;
      rf_wd = port0 ? '0 : io_rdata;
    end else if (st == S_MEM && is_load && (mmio || mem_ready)) begin
      rf_we = 1'b1;
      rf_wd = ld_val;
    end
  end
  assign hl_we = (st == S_AHI) && (op == OP_LDHL) && mem_ready;

  cpu8_regs u_regs (
    .clk(clk), .rst_n(rst_n), .ra(rid), .rb(opnd[RIW-1:0]),
    .rd_a(rd_a), .rd_b(rd_b), .we(rf_we), .wa(rid), .wd(rf_wd),
    .fl_we(fl_we), .fl_d(alu_fl), .hl_we(hl_we), .hl_d({mem_rdata, alo}),
    .hl(hl), .flags(flags)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_FETCH;
      pc   <= '0;
      sp   <= SP_INIT;
      ea   <= '0;
      ir   <= '0;
      opnd <= '0;
      alo  <= '0;
    end else begin
      case (st)
        S_FETCH: if (mem_ready) begin
          ir <= mem_rdata;
          pc <= pc + 1'b1;
          st <= S_DECODE;
        end
        S_DECODE: begin
          case (op)
            OP_LDW, OP_STW: begin
              if (mode) begin
                ea <= hl;
                st <= S_MEM;
              end else st <= S_ALO;
            end
            OP_LDHL: st <= S_ALO;
            OP_POP: begin
              sp <= sp - 1'b1;
              ea <= sp - 1'b1;
              st <= S_MEM;
            end
            default: st <= S_OPND;
          endcase
        end
        S_OPND: if (mem_ready) begin
          opnd <= mem_rdata;
          pc   <= pc + 1'b1;
          st   <= S_EXEC;
        end
        S_ALO: if (mem_ready) begin
          alo <= mem_rdata;
          pc  <= pc + 1'b1;
          st  <= S_AHI;
        end
        S_AHI: if (mem_ready) begin
          pc <= pc + 1'b1;
          if (op == OP_LDHL) st <= S_FETCH;
          else begin
            ea <= {mem_rdata, alo};
            st <= S_MEM;
          end
        end
        S_EXEC: begin
          st <= S_FETCH;
          case (op)
            OP_JNZ:  if (val != '0) pc <= hl;
            OP_PUSH: begin
              opnd <= val;
              ea   <= sp;
              st   <= S_MEM;
            end
            OP_OUT:  if (port0 && rd_a[0]) st <= S_HALT;
            default: ;
          endcase
        end
        S_MEM: begin
          if (mmio) begin
            if (is_store) begin
              case (ea[1:0])
                2'd0:    sp[DW-1:0]  <= mem_wdata;
                2'd1:    sp[AW-1:DW] <= mem_wdata;
                2'd2:    pc[DW-1:0]  <= mem_wdata;
                default: pc[AW-1:DW] <= mem_wdata;
              endcase
            end
            if (op == OP_PUSH) sp <= sp + 1'b1;
            st <= S_FETCH;
          end else if (mem_ready) begin
            if (op == OP_PUSH) sp <= sp + 1'b1;
            st <= S_FETCH;
          end
        end
        default: st <= S_HALT;
      endcase
    end
  end
endmodule

// File: rtl/cpu8_core_chk.sv
module cpu8_core_chk
  import cpu8_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          io_rd,
  input logic          io_wr,
  input logic [DW-1:0] io_addr,
  input logic          halted
);
  p_first_fetch_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mem_valid && !mem_we && mem_addr == '0 && !halted));

  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=>
      (mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  p_io_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_rd && io_wr));

  p_io_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd || io_wr) |=> !(io_rd || io_wr));

  p_port0_internal_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd || io_wr) |-> (io_addr != '0));

  p_halt_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  p_halt_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!mem_valid && !io_rd && !io_wr));
endmodule

bind cpu8_core cpu8_core_chk u_chk (.*);

// File: tb/cpu8_core_test.sv
module cpu8_core_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_valid, mem_we, io_rd, io_wr, halted;
  logic        mem_ready = 1'b0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, io_addr, io_wdata;
  logic [7:0]  mem_rdata = 8'h00;
  logic [7:0]  io_rdata = 8'h00;
  logic [15:0] lfsr = 16'hACE1;

  cpu8_core uut (.*);

  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct {bit we; int addr; int data; string tag;} txn_t;
  txn_t      exp_mem[$];
  txn_t      exp_io[$];
  bit [7:0]  img[int];
  string     tag_at[int];
  int        apc = 0;
  int        checks = 0;
  int        errors = 0;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // ---------------- program builder ----------------
  task automatic b(int v); img[apc] = v[7:0]; apc++; endtask
  task automatic sec(string t); tag_at[apc] = t; endtask
  function automatic int ins(int op, int m, int r); return (op << 4) | (m << 3) | r; endfunction
  task automatic ai(int op, int r, int imm); b(ins(op, 0, r)); b(imm); endtask
  task automatic ar(int op, int r, int s); b(ins(op, 1, r)); b(s); endtask
  task automatic st_abs(int r, int a); b(ins(9, 0, r)); b(a & 255); b(a >> 8); endtask
  task automatic ld_abs(int r, int a); b(ins(8, 0, r)); b(a & 255); b(a >> 8); endtask
  task automatic lda(int a); b(ins(10, 0, 0)); b(a & 255); b(a >> 8); endtask

  task automatic build_program();
    int patch;
    sec("R1");  st_abs(0, 'h1000); st_abs(7, 'h1001);
                ld_abs(1, 'hFFFD); st_abs(1, 'h1002); ld_abs(2, 'hFFFC); st_abs(2, 'h1003);
    sec("R4");  ai(7, 0, 'h3C); ai(0, 0, 'hE0); st_abs(0, 'h1010); st_abs(7, 'h1011);
                ai(7, 1, 1); ai(1, 1, 1); st_abs(1, 'h1012);
                ai(7, 2, 5); ai(2, 2, 7); st_abs(2, 'h1013); st_abs(7, 'h1014);
    sec("R3");  ai(7, 3, 'hF0); ar(3, 3, 0); ar(4, 3, 2); ar(5, 3, 1);
                st_abs(3, 'h1015); st_abs(7, 'h1016);
                ar(0, 0, 'hF9); st_abs(0, 'h1017);
    sec("R5");  ai(7, 0, 'h40); ai(6, 0, 'h20); st_abs(7, 'h1020);
                ai(6, 0, 'h40); st_abs(7, 'h1021); ai(6, 0, 'h41); st_abs(7, 'h1022);
                ai(7, 7, 'hA5); ai(0, 7, 1); st_abs(7, 'h1023);
                ai(1, 0, 0); st_abs(0, 'h1024); st_abs(7, 'h1025);
    sec("R6");  ai(7, 6, 'h55); ar(7, 0, 6); st_abs(0, 'h1030); st_abs(6, 'h1031);
    sec("R7");  ai(7, 1, 'h6B); lda('h2000); b(ins(9, 1, 1)); b(ins(8, 1, 2));
                st_abs(2, 'h1040); ld_abs(3, 'h1010); st_abs(3, 'h1041);
                st_abs(4, 'h1042); st_abs(5, 'h1043);
    sec("R10"); ld_abs(0, 'hFFFE); ld_abs(1, 'hFFFF); st_abs(0, 'h1050); st_abs(1, 'h1051);
                ai(7, 3, 'h40); st_abs(3, 'hFFFC); ld_abs(2, 'hFFFC); st_abs(2, 'h1052);
    sec("R9");  ai(7, 0, 'h12); ar(12, 0, 0); ai(12, 0, 'h99); b(ins(13, 0, 2)); b(ins(13, 0, 3));
                st_abs(2, 'h1060); st_abs(3, 'h1061); ld_abs(0, 'hFFFC); st_abs(0, 'h1062);
    sec("R8");  patch = apc; lda(0);
                ai(11, 0, 0); ai(7, 0, 'h11); st_abs(0, 'h1070);
                ai(7, 1, 0); ar(11, 0, 1); st_abs(0, 'h1071);
                ar(11, 0, 0); ai(7, 0, 'hEE); st_abs(0, 'h1072);
                img[patch + 1] = apc[7:0]; img[patch + 2] = apc[15:8];
                st_abs(0, 'h1073);
    sec("R11"); ai(14, 0, 'h33); st_abs(0, 'h1080); ai(7, 1, 'h45);
                ar(15, 0, 1); ai(15, 2, 'h81); ar(14, 3, 1); st_abs(3, 'h1081);
    sec("R12"); ai(14, 0, 0); st_abs(0, 'h1090); ai(7, 1, 'hFE); ai(15, 1, 0);
                st_abs(1, 'h1091); ai(7, 0, 1); ai(15, 0, 0);
                st_abs(0, 'h1F00); st_abs(0, 'h1F01);
  endtask

  // ---------------- behavioural reference model ----------------
  bit [7:0] m_mm[int];
  int       m_pc, m_sp;
  int       m_rg[8];
  string    m_cur;

  function automatic int m_mmio(int a);
    case (a & 3)
      0: return m_sp & 255;
      1: return (m_sp >> 8) & 255;
      2: return m_pc & 255;
      default: return (m_pc >> 8) & 255;
    endcase
  endfunction

  task automatic m_read(int a, output int d);
    a &= 'hFFFF;
    if (a >= 'hFFFC) d = m_mmio(a);
    else begin
      exp_mem.push_back('{1'b0, a, 0, m_cur});
      d = m_mm.exists(a) ? int'(m_mm[a]) : 0;
    end
  endtask

  task automatic m_write(int a, int d);
    a &= 'hFFFF;
    d &= 255;
    if (a >= 'hFFFC) begin
      case (a & 3)
        0: m_sp = (m_sp & 'hFF00) | d;
        1: m_sp = (m_sp & 'hFF) | (d << 8);
        2: m_pc = (m_pc & 'hFF00) | d;
        default: m_pc = (m_pc & 'hFF) | (d << 8);
      endcase
    end else begin
      exp_mem.push_back('{1'b1, a, d, m_cur});
      m_mm[a] = d[7:0];
    end
  endtask

  task automatic m_fetch(output int d);
    m_read(m_pc, d);
    m_pc = (m_pc + 1) & 'hFFFF;
  endtask

  function automatic int m_reg(int r); return (r == 6) ? 0 : m_rg[r]; endfunction
  task automatic m_setreg(int r, int v); if (r != 6) m_rg[r] = v & 255; endtask

  task automatic m_step(output bit halt);
    int ib, op, m, r, x, v, a, lo, hi, y, c, f, ea;
    halt = 0;
    v = 0;
    if (tag_at.exists(m_pc)) m_cur = tag_at[m_pc];
    m_fetch(ib);
    op = ib >> 4; m = (ib >> 3) & 1; r = ib & 7;
    a = m_reg(r);
    if (op <= 7 || op == 11 || op == 12 || op >= 14) begin
      m_fetch(x);
      v = (m != 0) ? m_reg(x & 7) : x;
    end
    if (op <= 7) begin
      f = m_rg[7]; c = 0;
      case (op)
        0: begin y = a + v; c = (y > 255) ? 1 : 0; end
        1: begin y = a + v + (f & 1); c = (y > 255) ? 1 : 0; end
        2, 6: begin y = a - v; c = (a < v) ? 1 : 0; end
        3: y = a & v;
        4: y = a | v;
        5: y = ~(a | v);
        default: y = v;
      endcase
      y &= 255;
      if (op != 7) f = (f & 'hFC) | c | (((y == 0) ? 1 : 0) << 1);
      if (op == 6) f = (f & 'hF0) | c | (((a == v) ? 1 : 0) << 1) |
                       (((a == v) ? 1 : 0) << 2) | (((a > v) ? 1 : 0) << 3);
      m_rg[7] = f;
      if (op != 6) m_setreg(r, y);
    end else begin
      case (op)
        8, 9: begin
          if (m != 0) ea = (m_rg[4] << 8) | m_rg[5];
          else begin m_fetch(lo); m_fetch(hi); ea = (hi << 8) | lo; end
          if (op == 8) begin m_read(ea, x); m_setreg(r, x); end
          else m_write(ea, a);
        end
        10: begin m_fetch(lo); m_fetch(hi); m_rg[4] = hi; m_rg[5] = lo; end
        11: if (v != 0) m_pc = (m_rg[4] << 8) | m_rg[5];
        12: begin m_write(m_sp, v); m_sp = (m_sp + 1) & 'hFFFF; end
        13: begin m_sp = (m_sp - 1) & 'hFFFF; m_read(m_sp, x); m_setreg(r, x); end
        14: begin
          if (v == 0) x = 0;
          else begin x = (v ^ 'h5A) & 255; exp_io.push_back('{1'b0, v, 0, m_cur}); end
          m_setreg(r, x);
        end
        default: begin
          if (v == 0) begin if ((a & 1) != 0) halt = 1; end
          else exp_io.push_back('{1'b1, v, a, m_cur});
        end
      endcase
    end
  endtask

  // ---------------- bus responder and per-cycle comparison ----------------
  always @(negedge clk) begin
    lfsr = {1'b0, lfsr[15:1]} ^ (lfsr[0] ? 16'hB400 : 16'h0000);
    if (!rst_n) mem_ready = 1'b0;
    else begin
      mem_ready = lfsr[0] | lfsr[1];
      if (mem_valid && mem_ready) begin
        if (exp_mem.size() == 0) check(1'b0, "R2", "unexpected bus transfer", int'(mem_addr), 0);
        else begin
          txn_t t;
          t = exp_mem.pop_front();
          check(mem_we == t.we && int'(mem_addr) == t.addr, t.tag, "bus dir/addr",
                int'(mem_we) * 65536 + int'(mem_addr), int'(t.we) * 65536 + t.addr);
          if (mem_we) check(int'(mem_wdata) == t.data, t.tag, "bus write data",
                            int'(mem_wdata), t.data);
        end
        if (mem_we) img[int'(mem_addr)] = mem_wdata;
        mem_rdata = img.exists(int'(mem_addr)) ? img[int'(mem_addr)] : 8'h00;
      end
      io_rdata = io_addr ^ 8'h5A;
      if (io_rd || io_wr) begin
        if (exp_io.size() == 0) check(1'b0, "R11", "unexpected port strobe", int'(io_addr), 0);
        else begin
          txn_t t;
          t = exp_io.pop_front();
          check(io_wr == t.we && int'(io_addr) == t.addr, t.tag, "port dir/addr",
                int'(io_wr) * 256 + int'(io_addr), int'(t.we) * 256 + t.addr);
          if (io_wr) check(int'(io_wdata) == t.data, t.tag, "port write data",
                           int'(io_wdata), t.data);
        end
      end
    end
  end

  initial begin
    bit h;
    build_program();
    m_mm = img;
    m_pc = 0; m_sp = 'h7C00; m_cur = "R1";
    for (int i = 0; i < 8; i++) m_rg[i] = 0;
    h = 0;
    for (int i = 0; i < 2000 && !h; i++) m_step(h);

    repeat (3) @(negedge clk);
    #1;
    check(mem_valid == 1'b1 && mem_we == 1'b0 && mem_addr == 16'h0000, "R1",
          "first request", int'(mem_valid) * 65536 + int'(mem_addr), 65536);
    check(halted == 1'b0, "R1", "halted after reset", int'(halted), 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 20000 && !halted; i++) @(posedge clk);
    if (!halted) check(1'b0, "R12", "watchdog expired before halt", 0, 1);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      #1;
      check(halted && !mem_valid && !io_rd && !io_wr, "R12", "quiet after halt",
            int'(mem_valid) + 2 * int'(io_rd) + 4 * int'(io_wr), 0);
    end
    check(exp_mem.size() == 0, "R2", "memory transfers left unseen", exp_mem.size(), 0);
    check(exp_io.size() == 0, "R11", "port accesses left unseen", exp_io.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule